// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is one programmable logic element of a fabric. A 4-input look-up table, whose truth table sits in configuration bits, produces a function output. A configuration bit picks whether the cell drives that output directly or the value a D flip-flop captured from it on the last rising clock edge. The cell has a second mode, arithmetic, that turns it into a one-bit full adder. In that mode it takes a carry from the neighbouring cell and passes its own carry straight to the next cell, without going through general routing, so a row of cells forms a ripple adder.

All configuration state is loaded through a serial shift path. The path has one data input and one data output, so any number of cells can be daisy-chained and loaded with a single bit stream. The shift path runs off the same clock as the flip-flop and advances only while the shift enable is high. Reset clears only the flip-flop and never the configuration.

Top module: `cfg_logic_cell`

## Requirements
- R1: With arithmetic mode off and output select 0 (combinational), `y` equals table bit number {lut_in[3],lut_in[2],lut_in[1],lut_in[0]}, with lut_in[3] as the most significant bit of the index.
- R2: A table word of 16'h8000 makes `y` the AND of all four inputs.
- R3: A table word of 16'h6666 makes `y` equal lut_in[0] XOR lut_in[1].
- R4: While `cfg_en` is high, each rising clock edge shifts `cfg_sin` into the cell's 18-bit configuration register, most significant bit first. A word is sent as the output-select bit, then the arithmetic bit, then table bits 15 down to 0. `cfg_sout` shows the bit that entered 18 shifts earlier, so cells can be chained. In a chain the word for the farthest cell is sent first.
- R5: While `cfg_en` is low, the configuration does not change, whatever `cfg_sin` does.
- R6: Output select 1 drives `y` from the flip-flop. Output select 0 drives `y` from the function output.
- R7: The flip-flop loads the function output on every rising clock edge on which `rst` is low.
- R8: With the arithmetic bit set, the function output is lut_in[0] ^ lut_in[1] ^ cin and `cout` is the majority of lut_in[0], lut_in[1] and cin. lut_in[3:2] and the table bits have no effect.
- R9: With the arithmetic bit clear, `cout` is 0.
- R10: A synchronous reset (`rst` high at a rising edge) clears the flip-flop and leaves every configuration bit unchanged.
- R11: Cells whose `cout` is wired to the next cell's `cin`, all in arithmetic mode, add two multi-bit operands and the carry-in of the first cell, with the carry out of the last cell as the top bit of the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flop and the configuration shift path |
| rst | input | 1 | Synchronous reset of the flip-flop only |
| cfg_en | input | 1 | Shift enable for the configuration path |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out, to the next cell |
| lut_in | input | 4 | Function inputs, bit 3 most significant in the table index |
| cin | input | 1 | Carry from the previous cell |
| cout | output | 1 | Carry to the next cell, 0 outside arithmetic mode |
| y | output | 1 | Cell output, combinational or registered |

## Verification
The bench targets the bit order of the shift path. It chains four cells and reads the last word back out. If the path reversed the word or swapped the select and mode bits, the cells would implement the wrong functions and the bits would come out in the wrong order. It also checks the table index order, because a design that reversed it would still pass symmetric words such as the AND but fail a random table. Other tests check that reset leaves the configuration intact, that the registered path lags by exactly one edge, and that the carry ripple is right at the full-scale corner 15+15+1. In arithmetic mode it varies the upper inputs, and it holds the carry input high outside that mode. A design that leaked the upper inputs into the sum, or drove a carry outside arithmetic mode, fails these checks.

// File: rtl/cell_cfg_pkg.sv
package cell_cfg_pkg;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_sel_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/cell_cfg_chain.sv
module cell_cfg_chain #(
   parameter int unsigned CHAIN_W = 18
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               shift_en,
   input  logic               sin,
   output logic               sout,
   output logic [CHAIN_W-1:0] cfg_q
);

   generate
      if (CHAIN_W < 3) begin : g_bad_w
         $error("cell_cfg_chain: CHAIN_W must be at least 3");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (shift_en) cfg_q <= {cfg_q[CHAIN_W-2:0], sin};
   end

   assign sout = cfg_q[CHAIN_W-1];

   a_r4_shift_in: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> cfg_q[0] == $past(sin));

   a_r4_shift_move: assert property (@(posedge clk) disable iff (rst)
      shift_en |=> sout == $past(cfg_q[CHAIN_W-2]));

   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      !shift_en |=> $stable(cfg_q));

endmodule

// File: rtl/cell_func.sv
module cell_func #(
   parameter int unsigned LUT_K     = 4,
   parameter bit          HAS_CARRY = 1'b1,
   localparam int unsigned TABLE_W  = 1 << LUT_K
) (
   input  logic [TABLE_W-1:0] lut_table,
   input  logic               arith,
   input  logic [LUT_K-1:0]   lut_in,
   input  logic               cin,
   output logic               f,
   output logic               cout
);
   import cell_cfg_pkg::*;

   logic table_bit;

   always_comb begin
      table_bit = lut_table[lut_in];
   end

   generate
      if (HAS_CARRY) begin : g_carry
         logic sum_bit;
         logic carry_bit;
         always_comb begin
            sum_bit   = lut_in[0] ^ lut_in[1] ^ cin;
            carry_bit = maj3(lut_in[0], lut_in[1], cin);
            f         = arith ? sum_bit : table_bit;
            cout      = arith ? carry_bit : 1'b0;
         end
      end else begin : g_no_carry
         always_comb begin
            f    = table_bit;
            cout = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/cell_out_stage.sv
module cell_out_stage
   import cell_cfg_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     f,
   input  out_sel_e out_sel,
   output logic     q,
   output logic     y
);

   always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= f;
   end

   always_comb begin
      y = (out_sel == OUT_REG) ? q : f;
   end

   a_r10_reset_clears: assert property (@(posedge clk)
      rst |=> q == 1'b0);

   a_r7_capture: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> q == $past(f));

   a_r6_reg_path: assert property (@(posedge clk) disable iff (rst)
      (out_sel == OUT_REG) |-> y == q);

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell #(
   parameter int unsigned LUT_K     = 4,
   parameter bit          HAS_CARRY = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_en,
   input  logic             cfg_sin,
   output logic             cfg_sout,
   input  logic [LUT_K-1:0] lut_in,
   input  logic             cin,
   output logic             cout,
   output logic             y
);
   import cell_cfg_pkg::*;

   localparam int unsigned TABLE_W = 1 << LUT_K;
   localparam int unsigned CHAIN_W = TABLE_W + 2;
   localparam int unsigned SEL_POS = CHAIN_W - 1;
   localparam int unsigned ARI_POS = CHAIN_W - 2;

   generate
      if (LUT_K < 2 || LUT_K > 6) begin : g_bad_k
         $error("cfg_logic_cell: LUT_K must lie in 2..6");
      end
   endgenerate

   logic [CHAIN_W-1:0] cfg_q;
   logic [TABLE_W-1:0] lut_table;
   logic               arith;
   out_sel_e           out_sel;
   logic               f;
   logic               q;

   cell_cfg_chain #(.CHAIN_W(CHAIN_W)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (cfg_en),
      .sin      (cfg_sin),
      .sout     (cfg_sout),
      .cfg_q    (cfg_q)
   );

   assign lut_table = cfg_q[TABLE_W-1:0];
   assign arith     = cfg_q[ARI_POS];
   assign out_sel   = out_sel_e'(cfg_q[SEL_POS]);

   cell_func #(.LUT_K(LUT_K), .HAS_CARRY(HAS_CARRY)) u_func (
      .lut_table (lut_table),
      .arith     (arith),
      .lut_in    (lut_in),
      .cin       (cin),
      .f         (f),
      .cout      (cout)
   );

   cell_out_stage u_out (
      .clk     (clk),
      .rst     (rst),
      .f       (f),
      .out_sel (out_sel),
      .q       (q),
      .y       (y)
   );

   a_r9_cout_idle: assert property (@(posedge clk) disable iff (rst)
      !arith |-> !cout);

   a_r8_carry: assert property (@(posedge clk) disable iff (rst)
      (arith && HAS_CARRY) |-> cout == maj3(lut_in[0], lut_in[1], cin));

   a_r10_cfg_kept: assert property (@(posedge clk)
      (rst && !cfg_en) |=> $stable(cfg_q));

endmodule

// File: tb/tb_cfg_logic_cell.sv
`timescale 1ns/1ps
module tb_cfg_logic_cell;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_en = 1'b0;
   logic       sin = 1'b0;
   logic       cin0 = 1'b0;
   logic [3:0] in0 = '0, in1 = '0, in2 = '0, in3 = '0;
   logic [3:0] sout, y, cout;
   int         vectors = 0;
   int         fails = 0;

   always #2.5 clk = ~clk;

   cfg_logic_cell dut (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sin(sin),
      .cfg_sout(sout[0]), .lut_in(in0), .cin(cin0), .cout(cout[0]), .y(y[0]));
   cfg_logic_cell c1 (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sin(sout[0]),
      .cfg_sout(sout[1]), .lut_in(in1), .cin(cout[0]), .cout(cout[1]), .y(y[1]));
   cfg_logic_cell c2 (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sin(sout[1]),
      .cfg_sout(sout[2]), .lut_in(in2), .cin(cout[1]), .cout(cout[2]), .y(y[2]));
   cfg_logic_cell c3 (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_sin(sout[2]),
      .cfg_sout(sout[3]), .lut_in(in3), .cin(cout[2]), .cout(cout[3]), .y(y[3]));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // word layout: {out_sel, arith, table[15:0]}
   task automatic load4(input logic [17:0] w0, w1, w2, w3);
      logic [71:0] s = {w3, w2, w1, w0};
      for (int i = 71; i >= 0; i--) begin
         @(negedge clk);
         cfg_en = 1'b1;
         sin = s[i];
      end
      @(negedge clk);
      cfg_en = 1'b0;
   endtask

   task automatic load0(input logic [17:0] w0);
      load4(w0, 18'h0, 18'h0, 18'h0);
   endtask

   task automatic t_reset_state();
      load0({1'b1, 1'b0, 16'hFFFF});
      @(negedge clk); #1;
      check("R10 reset state", y[0], 1'b0);
      rst = 1'b0;
      @(negedge clk); #1;
      check("R7 capture after reset", y[0], 1'b1);
   endtask

   task automatic t_index();
      logic [15:0] tbl = 16'hA5C3;
      load0({1'b0, 1'b0, tbl});
      for (int i = 0; i < 16; i++) begin
         in0 = 4'(i); #1;
         check("R1 table index", y[0], tbl[i]);
      end
   endtask

   task automatic t_and();
      load0({1'b0, 1'b0, 16'h8000});
      for (int i = 0; i < 16; i++) begin
         in0 = 4'(i); #1;
         check("R2 and4", y[0], &in0);
      end
   endtask

   task automatic t_xor();
      load0({1'b0, 1'b0, 16'h6666});
      for (int i = 0; i < 16; i++) begin
         in0 = 4'(i); #1;
         check("R3 xor01", y[0], in0[0] ^ in0[1]);
      end
   endtask

   task automatic t_order();
      logic [17:0] w3 = 18'b10_1100_1010_0111_0001;
      load4({1'b0, 1'b0, 16'h0001}, 18'h0, 18'h0, w3);
      for (int i = 0; i < 16; i++) begin
         in0 = 4'(i); #1;
         check("R4 word order", y[0], i == 0);
      end
      for (int i = 0; i < 18; i++) begin
         @(negedge clk); #1;
         check("R4 chain readout", sout[3], w3[17-i]);
         cfg_en = 1'b1;
         sin = 1'b0;
      end
      @(negedge clk);
      cfg_en = 1'b0;
   endtask

   task automatic t_hold();
      logic [15:0] tbl = 16'h3C96;
      load0({1'b0, 1'b0, tbl});
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         sin = i[0];
      end
      for (int i = 0; i < 16; i++) begin
         in0 = 4'(i); #1;
         check("R5 cfg held", y[0], tbl[i]);
      end
   endtask

   task automatic t_regout();
      load0({1'b1, 1'b0, 16'h6666});
      in0 = 4'b0001;
      @(negedge clk); #1;
      check("R7 registered", y[0], 1'b1);
      in0 = 4'b0011; #1;
      check("R6 reg path holds", y[0], 1'b1);
      @(negedge clk); #1;
      check("R7 next edge", y[0], 1'b0);
   endtask

   task automatic t_arith();
      load0({1'b0, 1'b1, 16'h0000});
      for (int v = 0; v < 32; v++) begin
         logic [4:0] b = 5'(v);
         in0 = {b[4:3], b[1:0]};
         cin0 = b[2]; #1;
         check("R8 sum", y[0], b[0] ^ b[1] ^ b[2]);
         check("R8 carry", cout[0], (b[0] & b[1]) | (b[0] & b[2]) | (b[1] & b[2]));
      end
      cin0 = 1'b0;
   endtask

   task automatic t_cout_idle();
      load0({1'b0, 1'b0, 16'hFFFF});
      cin0 = 1'b1;
      for (int i = 0; i < 16; i++) begin
         in0 = 4'(i); #1;
         check("R9 cout low", cout[0], 1'b0);
         check("R1 all ones", y[0], 1'b1);
      end
      cin0 = 1'b0;
   endtask

   task automatic t_reset_keep();
      load0({1'b1, 1'b0, 16'h6666});
      in0 = 4'b0001;
      @(negedge clk); #1;
      check("R10 pre reset", y[0], 1'b1);
      rst = 1'b1;
      @(negedge clk); #1;
      check("R10 flop cleared", y[0], 1'b0);
      rst = 1'b0;
      @(negedge clk); #1;
      check("R10 cfg kept", y[0], 1'b1);
      in0 = 4'b0011;
      @(negedge clk); #1;
      check("R10 cfg kept xor", y[0], 1'b0);
   endtask

   task automatic ripple_one(input logic [3:0] a, input logic [3:0] b, input logic c);
      logic [4:0] exp = 5'(a) + 5'(b) + 5'(c);
      in0 = {2'b11, b[0], a[0]};
      in1 = {2'b00, b[1], a[1]};
      in2 = {2'b10, b[2], a[2]};
      in3 = {2'b01, b[3], a[3]};
      cin0 = c; #1;
      check("R11 ripple sum", {cout[3], y}, exp);
   endtask

   task automatic t_ripple();
      logic [17:0] w = {1'b0, 1'b1, 16'h0000};
      load4(w, w, w, w);
      ripple_one(4'd3, 4'd5, 1'b0);
      ripple_one(4'd15, 4'd1, 1'b0);
      ripple_one(4'd9, 4'd7, 1'b1);
      ripple_one(4'd15, 4'd15, 1'b1);
      ripple_one(4'd0, 4'd0, 1'b0);
      ripple_one(4'd10, 4'd5, 1'b1);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      t_index();
      t_and();
      t_xor();
      t_order();
      t_hold();
      t_regout();
      t_arith();
      t_cout_idle();
      t_reset_keep();
      t_ripple();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule